// File: doc/BRIEF.md
# Hardware-Sequenced Flash Cycle Engine

This block carries out complete serial-flash operations on behalf of software. Software loads a 25-bit flash linear address, a buffer of up to 64 data bytes, a 2-bit cycle code and a byte count, then sets a single go bit. The engine produces every byte of the SPI traffic on its own. For a program or erase it sends the write-enable command first, then the command with its address and data, then polls the flash status register until the device is idle. When the operation ends it raises a done flag. A failed start raises an error flag instead.

Reads place the returned bytes in the data buffer. Byte i of a transfer lives in buffer word i/4, in bit lane (i mod 4)*8, so the 32-bit words are little-endian. The status flags are write-one-to-clear. The SPI side is a byte port: the engine holds `fl_req` with a byte and an end-of-frame mark until the serializer pulses `fl_ack`. The pulse returns the byte clocked in during that slot. Chip select is released after a byte marked as the last of its frame.

Top module: `flash_seq_engine`

Register words are chosen by `reg_addr`: 0 holds control, 1 holds status, 2 holds the flash address, and 16 to 31 hold buffer words 0 to 15.

## Requirements
- R1: After reset, control reads 0, the address register reads 0, `fl_req` is low, and status reads 0x0008. That value is the erase-size code 1 (4 KiB) in status bits 4:3 with every flag clear. The size codes are 0 for 256 B, 1 for 4 KiB, 2 for 8 KiB and 3 for 64 KiB.
- R2: The address register keeps only bits 24:0 of a write. Writing 0xFFFFFFFF reads back 0x01FFFFFF.
- R3: Cycle code 0 (control bits 2:1) is a read. It sends one frame: 0x03, then address bits 23:16, 15:8 and 7:0, then N bytes of 0x00 with the last byte marked. Returned byte i is stored at buffer word i/4, lane (i mod 4)*8, and status bit 0 (done) is set.
- R4: Control bits 13:8 hold N-1, so a cycle moves 1 to 64 bytes. The field reads back as written.
- R5: Cycle code 2 is a page write. It sends 0x06 alone in its own frame. Next comes one frame of 0x02, three address bytes and the N buffer bytes in order. It then repeats the frame {0x05, 0x00} until the byte returned in the second slot has bit 0 clear. Only then is done set.
- R6: Cycle code 3 is an erase. It sends 0x06 alone, then the frame {0x20, three address bytes}, then the same status polling as R5 before done is set.
- R7: A read or write with (address bits 7:0) + N > 256 sets status bit 1 (error) and produces no SPI traffic. A range that ends exactly on byte 255 runs normally.
- R8: Cycle code 1 sets status bit 2 (access error) together with bit 1 and produces no SPI traffic.
- R9: The go bit (control bit 0) always reads 0. Status bit 5 is high from the cycle after go until the operation ends.
- R10: Control writes made while a cycle is in progress are ignored entirely. They change neither the fields nor start anything.
- R11: Writing 1 clears status bits 0, 1 and 2, and writing 0 leaves them unchanged. Status bits 3, 4 and 5 are not writable.
- R12: Writing 1 to status bit 15 (lock-down) sets it, and it stays set until reset whatever is written later.
- R13: If the engine sets done in the same cycle that software writes 1 to clear it, done ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fl_req | output | 1 | SPI byte request, held until acknowledged |
| fl_tx | output | 8 | Byte to shift out |
| fl_end | output | 1 | Byte closes the current chip-select frame |
| fl_ack | input | 1 | Serializer finished the byte |
| fl_rx | input | 8 | Byte shifted in during that slot |

## Verification
Two things can happen in the same clock: the engine sets the done flag on the final SPI acknowledge, and software writes one to clear that flag. The bench makes them coincide by having its SPI responder drive the status clear write on the very cycle it acknowledges the last byte of a read. Afterwards done must still read as set, and a later separate clear must remove it. All SPI traffic is compared byte by byte, including the end-of-frame marks, against queued expectations, so a missing or extra poll frame is seen directly.

// File: rtl/flash_seq_engine.sv
module flash_seq_engine #(
  parameter int DATA_WORDS = 16,
  parameter int FLA_W      = 25,
  parameter logic [1:0] ERASE_GRAN = 2'd1,
  parameter logic [7:0] ERASE_OP   = 8'h20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [$clog2(DATA_WORDS):0]   reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output logic                          fl_req,
  output logic [7:0]                    fl_tx,
  output logic                          fl_end,
  input  logic                          fl_ack,
  input  logic [7:0]                    fl_rx
);
  localparam int NBYTES = DATA_WORDS * 4;
  localparam int CNT_W  = $clog2(NBYTES);
  localparam int WIX_W  = $clog2(DATA_WORDS);
  localparam int RA_W   = WIX_W + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_WREN, ST_CMD, ST_DATA, ST_POLL_OP, ST_POLL_RD} st_t;

  st_t               state;
  logic [1:0]        cyc;
  logic [CNT_W-1:0]  nm1, cnt;
  logic [1:0]        acnt;
  logic [FLA_W-1:0]  fla;
  logic [7:0]        mem [NBYTES];
  logic              st_done, st_err, st_ael, st_lock;

  wire busy   = state != ST_IDLE;
  wire hs     = fl_req && fl_ack;
  wire wr_ctl = reg_we && reg_addr == RA_W'(0);
  wire wr_sts = reg_we && reg_addr == RA_W'(1);
  wire wr_fla = reg_we && reg_addr == RA_W'(2);
  wire wr_buf = reg_we && reg_addr[RA_W-1];
  wire [WIX_W-1:0] wix = reg_addr[WIX_W-1:0];

  wire [1:0]       w_cyc = reg_wdata[2:1];
  wire [CNT_W-1:0] w_nm1 = reg_wdata[8 +: CNT_W];
  wire [8:0]       span  = {1'b0, fla[7:0]} + 9'(w_nm1);
  wire go        = wr_ctl && reg_wdata[0] && !busy;
  wire bad_code  = w_cyc == 2'd1;
  wire bad_range = (w_cyc != 2'd3) && span[8];
  wire start_ok  = go && !bad_code && !bad_range;

  wire last_data = cnt == nm1;
  wire set_done  = hs && ((state == ST_DATA && last_data && cyc == 2'd0) ||
                          (state == ST_POLL_RD && !fl_rx[0]));
  wire set_err   = go && (bad_code || bad_range);
  wire set_ael   = go && bad_code;

  logic [7:0] op;
  always_comb begin
    case (cyc)
      2'd0:    op = 8'h03;
      2'd2:    op = 8'h02;
      default: op = ERASE_OP;
    endcase
  end

  assign fl_req = busy;
  always_comb begin
    fl_tx  = 8'h00;
    fl_end = 1'b0;
    case (state)
      ST_WREN: begin fl_tx = 8'h06; fl_end = 1'b1; end
      ST_CMD: begin
        case (acnt)
          2'd0: fl_tx = op;
          2'd1: fl_tx = fla[23:16];
          2'd2: fl_tx = fla[15:8];
          default: fl_tx = fla[7:0];
        endcase
        fl_end = (cyc == 2'd3) && (acnt == 2'd3);
      end
      ST_DATA: begin
        fl_tx  = (cyc == 2'd0) ? 8'h00 : mem[cnt];
        fl_end = last_data;
      end
      ST_POLL_OP: fl_tx = 8'h05;
      ST_POLL_RD: fl_end = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      acnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_ok) begin
          state <= (w_cyc == 2'd0) ? ST_CMD : ST_WREN;
          acnt  <= '0;
          cnt   <= '0;
        end
        ST_WREN: if (hs) state <= ST_CMD;
        ST_CMD: if (hs) begin
          if (acnt == 2'd3) state <= (cyc == 2'd3) ? ST_POLL_OP : ST_DATA;
          acnt <= acnt + 2'd1;
        end
        ST_DATA: if (hs) begin
          if (last_data) state <= (cyc == 2'd0) ? ST_IDLE : ST_POLL_OP;
          cnt <= cnt + 1'b1;
        end
        ST_POLL_OP: if (hs) state <= ST_POLL_RD;
        ST_POLL_RD: if (hs) state <= fl_rx[0] ? ST_POLL_OP : ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      nm1 <= '0;
      fla <= '0;
    end else begin
      if (wr_ctl && !busy) begin
        cyc <= w_cyc;
        nm1 <= w_nm1;
      end
      if (wr_fla) fla <= reg_wdata[FLA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done <= 1'b0;
      st_err  <= 1'b0;
      st_ael  <= 1'b0;
      st_lock <= 1'b0;
    end else begin
      st_done <= (st_done & ~(wr_sts & reg_wdata[0])) | set_done;
      st_err  <= (st_err  & ~(wr_sts & reg_wdata[1])) | set_err;
      st_ael  <= (st_ael  & ~(wr_sts & reg_wdata[2])) | set_ael;
      st_lock <= st_lock | (wr_sts & reg_wdata[15]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'h00;
    end else begin
      if (wr_buf)
        for (int l = 0; l < 4; l++) mem[{wix, 2'(l)}] <= reg_wdata[8*l +: 8];
      if (hs && state == ST_DATA && cyc == 2'd0)
        mem[cnt] <= fl_rx;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[RA_W-1]) begin
      for (int l = 0; l < 4; l++) reg_rdata[8*l +: 8] = mem[{wix, 2'(l)}];
    end else begin
      case (reg_addr[WIX_W-1:0])
        WIX_W'(0): begin
          reg_rdata[2:1]        = cyc;
          reg_rdata[8 +: CNT_W] = nm1;
        end
        WIX_W'(1): reg_rdata[15:0] = {st_lock, 9'b0, busy, ERASE_GRAN, st_ael, st_err, st_done};
        WIX_W'(2): reg_rdata[FLA_W-1:0] = fla;
        default: ;
      endcase
    end
  end
endmodule

module flash_seq_engine_chk #(
  parameter int AW = 5,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          fl_req,
  input logic [7:0]    fl_tx,
  input logic          fl_end,
  input logic          fl_ack,
  input logic          st_done,
  input logic          st_lock,
  input logic [1:0]    cyc,
  input logic [CW-1:0] nm1
);
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fl_req);
  p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_ack |=> fl_req && $stable(fl_tx) && $stable(fl_end));
  p_lock_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    st_lock |=> st_lock);
  p_start_needs_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == AW'(0) && reg_wdata[0]));
  p_fields_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(cyc) && $stable(nm1));
  p_done_at_end_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> !busy);
endmodule

bind flash_seq_engine flash_seq_engine_chk #(.AW(RA_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fl_req(fl_req), .fl_tx(fl_tx), .fl_end(fl_end),
  .fl_ack(fl_ack), .st_done(st_done), .st_lock(st_lock), .cyc(cyc), .nm1(nm1)
);

// File: tb/sim_flash_seq_engine.sv
module sim_flash_seq_engine;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic fl_req, fl_end, fl_ack = 0;
  logic [7:0] fl_tx, fl_rx = 0;

  int n_cmp = 0, n_bad = 0;
  logic [17:0] exp_q[$];   // {clr, end, rx, tx}

  always #2 clk = ~clk;

  flash_seq_engine u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_req(fl_req), .fl_tx(fl_tx),
    .fl_end(fl_end), .fl_ack(fl_ack), .fl_rx(fl_rx));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic push(input logic [7:0] tx, input logic e, input logic [7:0] rx, input logic clr);
    exp_q.push_back({clr, e, rx, tx});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic settle(input string req);
    int k = 0;
    while (exp_q.size() != 0 && k < 400) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
    check(req, exp_q.size(), 0);
  endtask

  // monitor / responder
  initial begin
    logic [17:0] it;
    logic clr_on = 0;
    forever begin
      @(negedge clk);
      if (fl_ack) begin
        fl_ack = 0;
        if (clr_on) begin reg_we = 0; clr_on = 0; end
      end else if (fl_req) begin
        if (exp_q.size() == 0) begin
          check("unexpected SPI byte", {23'b0, fl_end, fl_tx}, 32'hFFFF_FFFF);
          fl_rx = 0;
        end else begin
          it = exp_q.pop_front();
          check("SPI byte R3/R5/R6", {23'b0, fl_end, fl_tx}, {23'b0, it[16], it[7:0]});
          fl_rx = it[15:8];
          if (it[17]) begin
            reg_we = 1; reg_addr = 5'd1; reg_wdata = 32'h1; clr_on = 1;
          end
        end
        fl_ack = 1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    rd(5'd0, v); check("R1 ctrl", v, 0);
    rd(5'd1, v); check("R1 status", v, 32'h8);
    rd(5'd2, v); check("R1 addr", v, 0);
    check("R1 req", {31'b0, fl_req}, 0);
    // R2
    wr(5'd2, 32'hFFFF_FFFF); rd(5'd2, v); check("R2 addr mask", v, 32'h01FF_FFFF);
    // R3 R4 read 4 bytes
    wr(5'd2, 32'h0012_3410);
    push(8'h03,0,0,0); push(8'h12,0,0,0); push(8'h34,0,0,0); push(8'h10,0,0,0);
    push(8'h00,0,8'hAA,0); push(8'h00,0,8'hBB,0); push(8'h00,0,8'hCC,0); push(8'h00,1,8'hDD,0);
    wr(5'd0, 32'h0301);
    wr(5'd0, 32'h3F07);                      // R10: ignored while busy
    rd(5'd1, v); check("R9 busy bit", v & 32'h20, 32'h20);
    settle("R3 read traffic");
    rd(5'd1, v); check("R3 done", v, 32'h9);
    rd(5'd16, v); check("R3 buffer lanes", v, 32'hDDCC_BBAA);
    rd(5'd0, v); check("R4 R9 R10 ctrl readback", v, 32'h0300);
    wr(5'd1, 32'h0000_0000); rd(5'd1, v); check("R11 write 0 keeps", v, 32'h9);
    wr(5'd1, 32'h1); rd(5'd1, v); check("R11 clear done", v, 32'h8);
    // R5 write 6 bytes
    wr(5'd2, 32'h0000_2040);
    wr(5'd16, 32'h4433_2211); wr(5'd17, 32'h8877_6655);
    push(8'h06,1,0,0);
    push(8'h02,0,0,0); push(8'h00,0,0,0); push(8'h20,0,0,0); push(8'h40,0,0,0);
    push(8'h11,0,0,0); push(8'h22,0,0,0); push(8'h33,0,0,0);
    push(8'h44,0,0,0); push(8'h55,0,0,0); push(8'h66,1,0,0);
    push(8'h05,0,0,0); push(8'h00,1,8'h01,0); push(8'h05,0,0,0); push(8'h00,1,8'h00,0);
    wr(5'd0, 32'h0505);
    settle("R5 write traffic");
    rd(5'd1, v); check("R5 done", v, 32'h9);
    wr(5'd1, 32'h1);
    // R6 erase
    wr(5'd2, 32'h0005_6000);
    push(8'h06,1,0,0);
    push(8'h20,0,0,0); push(8'h05,0,0,0); push(8'h60,0,0,0); push(8'h00,1,0,0);
    push(8'h05,0,0,0); push(8'h00,1,8'h00,0);
    wr(5'd0, 32'h0007);
    settle("R6 erase traffic");
    rd(5'd1, v); check("R6 done", v, 32'h9);
    wr(5'd1, 32'h1);
    // R7 crossing read, then exact edge write
    wr(5'd2, 32'h0000_00F0);
    wr(5'd0, 32'h1F01);
    settle("R7 no traffic");
    rd(5'd1, v); check("R7 error", v, 32'hA);
    wr(5'd1, 32'h2);
    wr(5'd2, 32'h0000_00FF);
    wr(5'd0, 32'h0105);
    settle("R7 two bytes at 0xFF no traffic");
    rd(5'd1, v); check("R7 error edge", v, 32'hA);
    wr(5'd1, 32'h2);
    push(8'h06,1,0,0);
    push(8'h02,0,0,0); push(8'h00,0,0,0); push(8'h00,0,0,0); push(8'hFF,0,0,0);
    push(8'h11,1,0,0); push(8'h05,0,0,0); push(8'h00,1,8'h00,0);
    wr(5'd0, 32'h0005);
    settle("R7 last byte of page runs");
    rd(5'd1, v); check("R7 edge done", v, 32'h9);
    wr(5'd1, 32'h1);
    // R8
    wr(5'd0, 32'h0003);
    settle("R8 no traffic");
    rd(5'd1, v); check("R8 access error", v, 32'hE);
    wr(5'd1, 32'h7); rd(5'd1, v); check("R11 clear all", v, 32'h8);
    // R11 read-only bits
    wr(5'd1, 32'h0038); rd(5'd1, v); check("R11 ro bits", v, 32'h8);
    // R12
    wr(5'd1, 32'h8000); rd(5'd1, v); check("R12 lock set", v, 32'h8008);
    wr(5'd1, 32'h0000); rd(5'd1, v); check("R12 lock stays", v, 32'h8008);
    wr(5'd1, 32'h7FFF); rd(5'd1, v); check("R12 lock stays 2", v, 32'h8008);
    // R13 same-cycle clear and set
    wr(5'd2, 32'h0000_0100);
    push(8'h03,0,0,0); push(8'h00,0,0,0); push(8'h01,0,0,0); push(8'h00,0,0,0);
    push(8'h00,0,8'h5A,0); push(8'h00,1,8'hC3,1);
    wr(5'd0, 32'h0101);
    settle("R13 traffic");
    rd(5'd1, v); check("R13 set wins", v, 32'h8009);
    rd(5'd16, v); check("R13 buffer", v & 32'hFFFF, 32'hC35A);
    wr(5'd1, 32'h1); rd(5'd1, v); check("R13 later clear", v, 32'h8008);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule